// File: doc/BRIEF.md
# Partial-Write General Register File

This block holds a bank of general-purpose registers for a 64-bit integer datapath. Every access uses a sub-register size, so a consumer can read or update a whole register, its low 32 bits, its low 16 bits, its low byte, or the second byte on the first few registers. The rules for merging differ by size. A 32-bit write clears the upper half of the register. A 16-bit or byte write leaves every bit outside its slice unchanged.

There is one write port and a parameterised number of combinational read ports, two by default. Each read port returns its slice right-aligned and zero-extended. Accesses that are not legal are caught. An illegal write is dropped and flagged for one cycle. An illegal read returns zero and raises a combinational error flag. The bank is cleared by a synchronous reset.

Top module: `gpr_slice_file`

Size codes on the 3-bit size fields: 0 = full width, 1 = 32-bit, 2 = 16-bit, 3 = low byte (bits 7:0), 4 = second byte (bits 15:8). Codes 5 to 7 are illegal.

## Requirements
- R1: While `rst` is high at a clock edge, all 16 registers become zero and `wr_err` becomes low.
- R2: A legal write with size 0 replaces all 64 bits with `wr_data`. When `wr_en` is low, no register changes.
- R3: A write with size 1 stores `wr_data[31:0]` in bits 31:0 and forces bits 63:32 to zero.
- R4: A write with size 2 stores `wr_data[15:0]` in bits 15:0 and keeps bits 63:16.
- R5: A write with size 3 stores `wr_data[7:0]` in bits 7:0 and keeps bits 63:8. It is legal for every index from 0 to 15.
- R6: A write with size 4 stores `wr_data[7:0]` in bits 15:8 and keeps all other bits. It is legal only for indices 0 to 3.
- R7: A write with size 5 to 7, or with size 4 to an index above 3, leaves every register unchanged. It drives `wr_err` high for exactly the cycle after the edge that sampled it.
- R8: A legal read returns the selected slice right-aligned and zero-extended to 64 bits. A size 4 read returns bits 15:8 in bits 7:0.
- R9: An illegal read (size 5 to 7, or size 4 with an index above 3) returns zero on its data lane and drives its `rd_err` bit high, combinationally.
- R10: Reads are combinational. A read of the register being written in the same cycle returns the value from before the write. The new value is visible after the clock edge.
- R11: Each read port decodes its own index and size, independently of the other port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_size | input | 3 | Write size code |
| wr_data | input | 64 | Write data, right-aligned |
| wr_err | output | 1 | Rejected-write flag, one cycle |
| rd_idx | input | 8 | Read indices, port p at bits [4p+3:4p] |
| rd_size | input | 6 | Read size codes, port p at bits [3p+2:3p] |
| rd_data | output | 128 | Read data, port p at bits [64p+63:64p] |
| rd_err | output | 2 | Per-port illegal-read flag |

## Verification
The bench builds the block with its default parameters: sixteen 64-bit registers, four registers with second-byte access, and two read ports. With these values the legality boundary between index 3 and index 4 can be tested. So can byte access on the upper eight indices, and the clearing of bits 63:32 on a 32-bit write. Two read ports make it possible to read different slices of one register, or different registers, in the same cycle. They also let the bench watch a register while it is being written.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

   localparam int SIZE_W = 3;

   typedef enum logic [SIZE_W-1:0] {
      SZ_FULL = 3'd0,
      SZ_W32  = 3'd1,
      SZ_W16  = 3'd2,
      SZ_LOB  = 3'd3,
      SZ_HIB  = 3'd4
   } acc_size_e;

   function automatic logic size_known(input logic [SIZE_W-1:0] s);
      return (s <= SZ_HIB);
   endfunction

endpackage

// File: rtl/gpr_access_check.sv
module gpr_access_check
   import gpr_pkg::*;
#(
   parameter int IDX_W          = 4,
   parameter int HIGH_BYTE_REGS = 4
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [SIZE_W-1:0] size,
   output logic              legal
);
   localparam int HB_LIMIT = HIGH_BYTE_REGS;

   if (HIGH_BYTE_REGS < 0 || HIGH_BYTE_REGS > (1 << IDX_W)) begin : g_bad_hb
      $error("HIGH_BYTE_REGS out of range");
   end

   logic hb_ok;

   always_comb begin
      hb_ok = (int'(idx) < HB_LIMIT);
      if (!size_known(size))
         legal = 1'b0;
      else if (size == SZ_HIB)
         legal = hb_ok;
      else
         legal = 1'b1;
   end
endmodule

// File: rtl/gpr_write_merge.sv
module gpr_write_merge
   import gpr_pkg::*;
#(
   parameter int REG_W = 64
) (
   input  logic [REG_W-1:0]  old_val,
   input  logic [REG_W-1:0]  data,
   input  logic [SIZE_W-1:0] size,
   output logic [REG_W-1:0]  new_val
);
   if (REG_W < 32 || (REG_W % 16) != 0) begin : g_bad_w
      $error("REG_W must be a multiple of 16 and at least 32");
   end

   always_comb begin
      new_val = old_val;
      case (size)
         SZ_FULL: new_val = data;
         SZ_W32:  new_val = {{(REG_W-32){1'b0}}, data[31:0]};
         SZ_W16:  new_val = {old_val[REG_W-1:16], data[15:0]};
         SZ_LOB:  new_val = {old_val[REG_W-1:8], data[7:0]};
         SZ_HIB:  new_val = {old_val[REG_W-1:16], data[7:0], old_val[7:0]};
         default: new_val = old_val;
      endcase
   end
endmodule

// File: rtl/gpr_read_slice.sv
module gpr_read_slice
   import gpr_pkg::*;
#(
   parameter int REG_W = 64
) (
   input  logic [REG_W-1:0]  value,
   input  logic [SIZE_W-1:0] size,
   input  logic              legal,
   output logic [REG_W-1:0]  data
);
   always_comb begin
      data = '0;
      if (legal) begin
         case (size)
            SZ_FULL: data = value;
            SZ_W32:  data[31:0] = value[31:0];
            SZ_W16:  data[15:0] = value[15:0];
            SZ_LOB:  data[7:0]  = value[7:0];
            SZ_HIB:  data[7:0]  = value[15:8];
            default: data = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpr_slice_file.sv
module gpr_slice_file
   import gpr_pkg::*;
#(
   parameter int NUM_REGS       = 16,
   parameter int REG_W          = 64,
   parameter int HIGH_BYTE_REGS = 4,
   parameter int NUM_RD         = 2,
   localparam int IDX_W         = $clog2(NUM_REGS)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [SIZE_W-1:0]        wr_size,
   input  logic [REG_W-1:0]         wr_data,
   output logic                     wr_err,
   input  logic [NUM_RD*IDX_W-1:0]  rd_idx,
   input  logic [NUM_RD*SIZE_W-1:0] rd_size,
   output logic [NUM_RD*REG_W-1:0]  rd_data,
   output logic [NUM_RD-1:0]        rd_err
);
   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS) begin : g_bad_n
      $error("NUM_REGS must be a power of two, at least 2");
   end
   if (NUM_RD < 1) begin : g_bad_rd
      $error("NUM_RD must be at least 1");
   end

   logic [REG_W-1:0] regs [NUM_REGS];
   logic             wr_legal;
   logic [REG_W-1:0] wr_merged;

   gpr_access_check #(.IDX_W(IDX_W), .HIGH_BYTE_REGS(HIGH_BYTE_REGS)) u_wchk (
      .idx   (wr_idx),
      .size  (wr_size),
      .legal (wr_legal)
   );

   gpr_write_merge #(.REG_W(REG_W)) u_merge (
      .old_val (regs[wr_idx]),
      .data    (wr_data),
      .size    (wr_size),
      .new_val (wr_merged)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
         wr_err <= 1'b0;
      end else begin
         if (wr_en && wr_legal) regs[wr_idx] <= wr_merged;
         wr_err <= wr_en && !wr_legal;
      end
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (regs[0] == '0 && regs[NUM_REGS-1] == '0 && !wr_err));

   // R7
   bad_wr_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_legal) |=> wr_err);

   // R7
   bad_wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_legal) |=> (regs[$past(wr_idx)] == $past(regs[wr_idx])));

   // R3
   w32_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_size == SZ_W32) |=> (regs[$past(wr_idx)][REG_W-1:32] == '0));

   // R4
   w16_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_size == SZ_W16)
      |=> (regs[$past(wr_idx)][REG_W-1:16] == $past(regs[wr_idx][REG_W-1:16])));

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      logic [IDX_W-1:0]  p_idx;
      logic [SIZE_W-1:0] p_size;
      logic              p_legal;
      logic [REG_W-1:0]  p_data;

      assign p_idx  = rd_idx[p*IDX_W +: IDX_W];
      assign p_size = rd_size[p*SIZE_W +: SIZE_W];

      gpr_access_check #(.IDX_W(IDX_W), .HIGH_BYTE_REGS(HIGH_BYTE_REGS)) u_rchk (
         .idx   (p_idx),
         .size  (p_size),
         .legal (p_legal)
      );

      gpr_read_slice #(.REG_W(REG_W)) u_slice (
         .value (regs[p_idx]),
         .size  (p_size),
         .legal (p_legal),
         .data  (p_data)
      );

      assign rd_data[p*REG_W +: REG_W] = p_data;
      assign rd_err[p] = !p_legal;

      // R8
      rd_byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
         (p_size == SZ_LOB || p_size == SZ_HIB) |-> (rd_data[p*REG_W+8 +: REG_W-8] == '0));

      // R9
      rd_bad_zero_chk: assert property (@(posedge clk) disable iff (rst)
         rd_err[p] |-> (rd_data[p*REG_W +: REG_W] == '0));
   end
endmodule

// File: tb/gpr_slice_file_tb_top.sv
module gpr_slice_file_tb_top;
   logic         clk = 1'b0;
   logic         rst;
   logic         wr_en;
   logic [3:0]   wr_idx;
   logic [2:0]   wr_size;
   logic [63:0]  wr_data;
   logic         wr_err;
   logic [7:0]   rd_idx;
   logic [5:0]   rd_size;
   logic [127:0] rd_data;
   logic [1:0]   rd_err;

   int checks = 0;
   int fails  = 0;
   logic [63:0] model [16];
   bit done = 1'b0;

   always #10 clk = ~clk;

   gpr_slice_file dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size),
      .wr_data(wr_data), .wr_err(wr_err), .rd_idx(rd_idx), .rd_size(rd_size),
      .rd_data(rd_data), .rd_err(rd_err)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] exp_read(input int idx, input logic [2:0] sz);
      logic [63:0] v = model[idx];
      case (sz)
         3'd0: return v;
         3'd1: return {32'd0, v[31:0]};
         3'd2: return {48'd0, v[15:0]};
         3'd3: return {56'd0, v[7:0]};
         3'd4: return (idx < 4) ? {56'd0, v[15:8]} : 64'd0;
         default: return 64'd0;
      endcase
   endfunction

   task automatic set_rd(input int p, input int idx, input logic [2:0] sz);
      rd_idx[p*4 +: 4]  = idx[3:0];
      rd_size[p*3 +: 3] = sz;
   endtask

   task automatic rd_chk(input string tag, input int p, input int idx, input logic [2:0] sz);
      set_rd(p, idx, sz);
      #1;
      chk(tag, rd_data[p*64 +: 64], exp_read(idx, sz));
   endtask

   task automatic do_write(input string tag, input int idx, input logic [2:0] sz,
                           input logic [63:0] d);
      bit ok;
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx[3:0]; wr_size = sz; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      ok = (sz <= 3'd3) || (sz == 3'd4 && idx < 4);
      chk({tag, " wr_err"}, {63'd0, wr_err}, {63'd0, !ok});
      if (ok) begin
         case (sz)
            3'd0: model[idx] = d;
            3'd1: model[idx] = {32'd0, d[31:0]};
            3'd2: model[idx][15:0] = d[15:0];
            3'd3: model[idx][7:0] = d[7:0];
            default: model[idx][15:8] = d[7:0];
         endcase
      end
   endtask

   task automatic t_reset;
      rst = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_size = '0; wr_data = '0;
      rd_idx = '0; rd_size = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 16; i++) model[i] = '0;
      chk("R1 wr_err low", {63'd0, wr_err}, 64'd0);
      for (int i = 0; i < 16; i++) rd_chk("R1 reg zero", 0, i, 3'd0);
   endtask

   task automatic t_full;
      do_write("R2 full", 5, 3'd0, 64'hDEAD_BEEF_0123_4567);
      do_write("R2 full", 15, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
      rd_chk("R2 full read", 0, 5, 3'd0);
      rd_chk("R2 full read", 1, 15, 3'd0);
      @(negedge clk);
      wr_en = 1'b0; wr_idx = 4'd5; wr_size = 3'd0; wr_data = '0;
      @(negedge clk);
      rd_chk("R2 wr_en low no change", 0, 5, 3'd0);
   endtask

   task automatic t_w32;
      do_write("R3 w32", 15, 3'd1, 64'h1111_2222_3333_4444);
      rd_chk("R3 upper cleared", 0, 15, 3'd0);
      chk("R3 literal", rd_data[63:0], 64'h0000_0000_3333_4444);
   endtask

   task automatic t_w16_w8;
      do_write("R4 setup", 9, 3'd0, 64'hAAAA_BBBB_CCCC_DDDD);
      do_write("R4 w16", 9, 3'd2, 64'hFFFF_FFFF_FFFF_1234);
      rd_chk("R4 keep upper", 0, 9, 3'd0);
      chk("R4 literal", rd_data[63:0], 64'hAAAA_BBBB_CCCC_1234);
      do_write("R5 w8 idx9", 9, 3'd3, 64'h0000_0000_0000_0077);
      chk("R5 literal", (set_and_get(0, 9, 3'd0)), 64'hAAAA_BBBB_CCCC_1277);
      for (int i = 4; i < 16; i++) begin
         do_write("R5 lob any idx", i, 3'd3, 64'(8'h40 + i));
         rd_chk("R5 lob read", 1, i, 3'd0);
      end
   endtask

   function automatic logic [63:0] set_and_get(input int p, input int idx, input logic [2:0] sz);
      return model[idx] & ((sz == 3'd0) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0);
   endfunction

   task automatic t_hib;
      do_write("R6 setup", 2, 3'd0, 64'h0102_0304_0506_0708);
      do_write("R6 hib", 2, 3'd4, 64'h0000_0000_0000_00C3);
      rd_chk("R6 hib merge", 0, 2, 3'd0);
      chk("R6 literal", rd_data[63:0], 64'h0102_0304_0506_C308);
      rd_chk("R8 hib read", 1, 2, 3'd4);
      chk("R8 hib literal", rd_data[127:64], 64'h0000_0000_0000_00C3);
      do_write("R6 hib idx3", 3, 3'd4, 64'h5A);
      rd_chk("R6 hib idx3", 0, 3, 3'd0);
   endtask

   task automatic t_illegal_wr;
      do_write("R7 setup", 4, 3'd0, 64'h7777_6666_5555_4444);
      do_write("R7 hib idx4", 4, 3'd4, 64'hEE);
      rd_chk("R7 idx4 unchanged", 0, 4, 3'd0);
      for (int s = 5; s < 8; s++) begin
         do_write("R7 bad size", 4, s[2:0], 64'h0);
         rd_chk("R7 bad size unchanged", 0, 4, 3'd0);
      end
      @(negedge clk);
      chk("R7 one cycle pulse", {63'd0, wr_err}, 64'd0);
   endtask

   task automatic t_reads;
      do_write("R8 setup", 1, 3'd0, 64'h8899_AABB_CCDD_EEFF);
      rd_chk("R8 full", 0, 1, 3'd0);
      rd_chk("R8 w32", 0, 1, 3'd1);
      rd_chk("R8 w16", 0, 1, 3'd2);
      rd_chk("R8 lob", 1, 1, 3'd3);
      chk("R8 lob literal", rd_data[127:64], 64'hFF);
      rd_chk("R11 port0 w16 while port1 lob", 0, 1, 3'd2);
      chk("R11 port1 still lob", rd_data[127:64], 64'hFF);
      set_rd(0, 5, 3'd4); set_rd(1, 1, 3'd4);
      #1;
      chk("R9 hib idx5 zero", rd_data[63:0], 64'd0);
      chk("R9 rd_err port0", {62'd0, rd_err}, 64'h1);
      chk("R11 port1 legal hib", rd_data[127:64], 64'hEE);
      set_rd(0, 1, 3'd0); set_rd(1, 1, 3'd6);
      #1;
      chk("R9 size6 zero", rd_data[127:64], 64'd0);
      chk("R9 rd_err port1", {62'd0, rd_err}, 64'h2);
   endtask

   task automatic t_bypass;
      @(negedge clk);
      set_rd(0, 7, 3'd0);
      wr_en = 1'b1; wr_idx = 4'd7; wr_size = 3'd0; wr_data = 64'hCAFE_F00D_1234_5678;
      #1;
      chk("R10 old value same cycle", rd_data[63:0], model[7]);
      @(negedge clk);
      wr_en = 1'b0;
      model[7] = 64'hCAFE_F00D_1234_5678;
      chk("R10 new value after edge", rd_data[63:0], model[7]);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_full();
            t_w32();
            t_w16_w8();
            t_hib();
            t_illegal_wr();
            t_reads();
            t_bypass();
            done = 1'b1;
         end
         begin
            repeat (20000) @(posedge clk);
            if (!done) begin
               checks++; fails++;
               $display("FAIL watchdog actual=timeout expected=completion");
            end
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule